// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an external asynchronous static RAM of 256K words by 16 bits. A requester presents an 18-bit word address, a read/write flag, 16 bits of write data and a two-bit byte mask, raises `req` for one cycle while `ready` is high, and later receives a one-cycle `done` pulse. For a read, the masked word arrives on `rdata` in that same cycle. Toward the memory the block drives active-low chip select, write strobe, output enable and two lane enables, plus the address and a split data bus made of an output word, an input word and a drive enable.

Timing limits are given as nanosecond parameters together with the clock period. The block turns each limit into a whole number of cycles, rounding up with a floor of one. These counts set how long output enable stays low on a read, how long the write strobe stays low, and how long the bus stays undriven after output enable is released. Every write has one setup cycle and one hold cycle around its strobe. A parameter chooses which pin acts as the strobe: write enable, chip select, or the lane enables.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select, write strobe, output enable and both lane enables are high (inactive), the drive enable is low, `ready` is high and `done` is low.
- R2: Cycle counts are ceil(limit_ns / CLK_NS) with a minimum of 1. With the defaults (20 ns clock, 45 ns access, 35 ns strobe, 15 ns release) this gives a read window of 3 cycles, a write strobe of 2 cycles and a turnaround of 1 cycle.
- R3: A read accepted at clock edge k holds chip select low, write strobe high and output enable low for the read-window cycles that follow edge k, with the request's address on the address pins. Lane enable bit 1 (data bits 15..8) is low exactly when mask bit 1 is set. Lane enable bit 0 (bits 7..0) is low exactly when mask bit 0 is set.
- R4: A read samples the input word on the edge that ends the read window. `done` is high for exactly the one cycle after that edge, and `rdata` then holds the sampled word with every unmasked lane forced to zero.
- R5: After a read releases output enable, all strobes stay inactive and `ready` stays low for the turnaround count of cycles. The drive enable is never raised fewer than that many cycles after output enable was last low.
- R6: With WMODE=0 (write-enable strobe), a write has one setup cycle (chip select low, lane enables per mask, write strobe high), then the write-strobe count of cycles with the write strobe low, then one hold cycle with the write strobe high. Address, data and lane enables stay constant across all three phases. `done` pulses in the first idle cycle after the hold cycle.
- R7: The drive enable is high only during the three write phases and only while output enable is high. Output enable and the write strobe are never low at the same time.
- R8: With WMODE=1 (chip-select strobe), the setup and hold cycles have chip select high and the write strobe low, and chip select is low only in the strobe phase.
- R9: With WMODE=2 (lane-enable strobe), chip select and the write strobe are low across all three phases, and the lane enables follow the mask only in the strobe phase, staying high in setup and hold.
- R10: A request raised while `ready` is low is ignored. The access in progress runs unchanged and memory is not altered.
- R11: With mask 00, both lane enables stay high through the whole access, a write changes no memory, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle access request, taken only while ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 1 = bits 15..8, bit 0 = bits 7..0 |
| ready | output | 1 | Sequencer idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, unmasked lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 1 = upper lane |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |

## Verification
The assertions assume that `req` is only meaningful while `ready` is high and that the memory returns stable data for the whole read window. The bench meets the first assumption by waiting for `ready` before each request, except in the deliberate busy-request case, where the design must ignore the request. It meets the second with a memory model that updates its output word only on the falling clock edge, based on the pins it sees. Unselected lanes return a junk pattern so that the lane masking on `rdata` is visible at the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RTURN, S_WSET, S_WPUL, S_WHOLD
  } seq_t;

  localparam int WM_WE = 0;
  localparam int WM_CE = 1;
  localparam int WM_BE = 2;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic gate;   // lanes follow the mask
    logic dq_oe;
  } strb_t;

  // nanoseconds to whole cycles, rounding up, never below one
  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int cnt_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic strb_t strobe_of(seq_t s, int mode);
    strb_t r;
    r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, gate: 1'b0, dq_oe: 1'b0};
    case (s)
      S_RD: begin
        r.ce_n = 1'b0;
        r.oe_n = 1'b0;
        r.gate = 1'b1;
      end
      S_WPUL: begin
        r.ce_n  = 1'b0;
        r.we_n  = 1'b0;
        r.gate  = 1'b1;
        r.dq_oe = 1'b1;
      end
      S_WSET, S_WHOLD: begin
        r.dq_oe = 1'b1;
        if (mode == WM_CE) begin
          r.we_n = 1'b0;
          r.gate = 1'b1;
        end else if (mode == WM_BE) begin
          r.ce_n = 1'b0;
          r.we_n = 1'b0;
        end else begin
          r.ce_n = 1'b0;
          r.gate = 1'b1;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asram_wait.sv
module asram_wait #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/asram_lane_merge.sv
module asram_lane_merge #(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   mask,
  output logic [LANES*8-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*8 +: 8] = mask[l] ? din[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 20,
  parameter int T_AA_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_HZOE_NS = 15,
  parameter int WMODE     = WM_WE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                ready,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_o,
  input  logic [DATA_W-1:0]   mem_dq_i,
  output logic                mem_dq_oe
);
  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = ns2cyc(T_AA_NS, CLK_NS);
  localparam int WR_CYC   = ns2cyc(T_PWE_NS, CLK_NS);
  localparam int TURN_CYC = ns2cyc(T_HZOE_NS, CLK_NS);
  localparam int MAXC     = (RD_CYC > WR_CYC) ?
                            ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC) :
                            ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
  localparam int CW       = cnt_bits(MAXC);
  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LD   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);
  localparam int HZ_W     = cnt_bits(TURN_CYC + 1);

  seq_t st, st_n;
  logic cnt_load, cnt_zero;
  logic [CW-1:0] cnt_val;
  strb_t strb_n;
  logic [LANES-1:0]  mask_q, mask_n;
  logic [DATA_W-1:0] rd_merged;

  // named events
  logic accept, rd_last, wr_last;
  assign accept  = (st == S_IDLE) && req;
  assign rd_last = (st == S_RD) && cnt_zero;
  assign wr_last = (st == S_WHOLD);

  asram_wait #(.W(CW)) u_wait (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  asram_lane_merge #(.LANES(LANES)) u_merge (
    .din(mem_dq_i), .mask(mask_q), .dout(rd_merged)
  );

  always_comb begin
    st_n     = st;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (st)
      S_IDLE: if (req) begin
        if (req_we) st_n = S_WSET;
        else begin
          st_n = S_RD; cnt_load = 1'b1; cnt_val = RD_LD;
        end
      end
      S_RD: if (cnt_zero) begin
        st_n = S_RTURN; cnt_load = 1'b1; cnt_val = TURN_LD;
      end
      S_RTURN: if (cnt_zero) st_n = S_IDLE;
      S_WSET: begin
        st_n = S_WPUL; cnt_load = 1'b1; cnt_val = WR_LD;
      end
      S_WPUL:  if (cnt_zero) st_n = S_WHOLD;
      S_WHOLD: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign strb_n = strobe_of(st_n, WMODE);
  assign mask_n = accept ? req_mask : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mask_q    <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      st        <= st_n;
      mem_ce_n  <= strb_n.ce_n;
      mem_we_n  <= strb_n.we_n;
      mem_oe_n  <= strb_n.oe_n;
      mem_be_n  <= strb_n.gate ? ~mask_n : '1;
      mem_dq_oe <= strb_n.dq_oe;
      mask_q    <= mask_n;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      done <= rd_last || wr_last;
      if (rd_last) rdata <= rd_merged;
    end
  end

  assign ready = (st == S_IDLE);

  // cycles since output enable was last low, saturating at the turnaround
  logic [HZ_W-1:0] hz_cnt;
  always_ff @(posedge clk) begin
    if (rst)                           hz_cnt <= HZ_W'(TURN_CYC);
    else if (!mem_oe_n)                hz_cnt <= '0;
    else if (hz_cnt < HZ_W'(TURN_CYC)) hz_cnt <= hz_cnt + 1'b1;
  end

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R7
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R5
  hz_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (hz_cnt == HZ_W'(TURN_CYC)));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && req) |=> $stable(mem_addr) && $stable(mem_dq_o));

  if (WMODE == WM_WE) begin : g_we_chk
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(mem_we_n) && mem_dq_oe) |->
        ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_be_n)));
  end
endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int CLK = 20;
  localparam int RDC = (45 + CLK - 1) / CLK;   // R2
  localparam int WRC = (35 + CLK - 1) / CLK;
  localparam int TNC = (15 + CLK - 1) / CLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic req = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;

  logic        rdy[3], dn[3], ce[3], we[3], oe[3], dqoe[3];
  logic [15:0] rd[3], dqo[3], dqi[3];
  logic [1:0]  be[3];
  logic [17:0] ad[3];

  asram_ctrl #(.WMODE(0)) u0 (.clk(clk), .rst(rst), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .ready(rdy[0]),
    .done(dn[0]), .rdata(rd[0]), .mem_ce_n(ce[0]), .mem_we_n(we[0]), .mem_oe_n(oe[0]),
    .mem_be_n(be[0]), .mem_addr(ad[0]), .mem_dq_o(dqo[0]), .mem_dq_i(dqi[0]),
    .mem_dq_oe(dqoe[0]));
  asram_ctrl #(.WMODE(1)) u1 (.clk(clk), .rst(rst), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .ready(rdy[1]),
    .done(dn[1]), .rdata(rd[1]), .mem_ce_n(ce[1]), .mem_we_n(we[1]), .mem_oe_n(oe[1]),
    .mem_be_n(be[1]), .mem_addr(ad[1]), .mem_dq_o(dqo[1]), .mem_dq_i(dqi[1]),
    .mem_dq_oe(dqoe[1]));
  asram_ctrl #(.WMODE(2)) u2 (.clk(clk), .rst(rst), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .ready(rdy[2]),
    .done(dn[2]), .rdata(rd[2]), .mem_ce_n(ce[2]), .mem_we_n(we[2]), .mem_oe_n(oe[2]),
    .mem_be_n(be[2]), .mem_addr(ad[2]), .mem_dq_o(dqo[2]), .mem_dq_i(dqi[2]),
    .mem_dq_oe(dqoe[2]));

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  // behavioural reference: 0 idle, 1 read, 2 write
  int act = 0, t = 0;
  bit exp_done = 0;
  logic [15:0] exp_rd = '0;
  logic [17:0] m_addr;
  logic [15:0] m_data;
  logic [1:0]  m_mask;
  logic [15:0] shadow [int];

  function automatic logic [15:0] shadow_get(logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      act = 0; exp_done = 0;
    end else begin
      exp_done = 0;
      if (act == 0) begin
        if (req) begin
          act = req_we ? 2 : 1; t = 0;
          m_addr = req_addr; m_data = req_wdata; m_mask = req_mask;
        end
      end else begin
        t++;
        if (act == 1 && t == RDC) begin
          exp_done = 1;
          exp_rd = shadow_get(m_addr);
          if (!m_mask[1]) exp_rd[15:8] = 8'h00;
          if (!m_mask[0]) exp_rd[7:0]  = 8'h00;
        end
        if (act == 1 && t == RDC + TNC) act = 0;
        if (act == 2 && t == WRC + 2) begin
          logic [15:0] v;
          v = shadow_get(m_addr);
          if (m_mask[1]) v[15:8] = m_data[15:8];
          if (m_mask[0]) v[7:0]  = m_data[7:0];
          shadow[int'(m_addr)] = v;
          act = 0; exp_done = 1;
        end
      end
    end
  end

  // per-instance memory models, updated on the falling edge from the pins
  for (genvar g = 0; g < 3; g++) begin : g_mem
    logic [15:0] mm [int];
    logic [1:0]  prev_act = 2'b00;
    logic [15:0] prev_dq = '0;
    logic [17:0] prev_ad = '0;
    logic [15:0] din_r = 16'hDEAD;
    assign dqi[g] = din_r;
    always @(negedge clk) begin
      logic [1:0]  a_now;
      logic [15:0] cur;
      for (int l = 0; l < 2; l++) a_now[l] = !ce[g] && !we[g] && !be[g][l];
      for (int l = 0; l < 2; l++)
        if (prev_act[l] && !a_now[l]) begin
          cur = mm.exists(int'(prev_ad)) ? mm[int'(prev_ad)] : 16'h0000;
          cur[l*8 +: 8] = prev_dq[l*8 +: 8];
          mm[int'(prev_ad)] = cur;
        end
      prev_act = a_now; prev_dq = dqo[g]; prev_ad = ad[g];
      if (!ce[g] && !oe[g] && we[g]) begin
        cur = mm.exists(int'(ad[g])) ? mm[int'(ad[g])] : 16'h0000;
        for (int l = 0; l < 2; l++) if (be[g][l]) cur[l*8 +: 8] = 8'hA5;
        din_r = cur;
      end else din_r = 16'hDEAD;
    end
  end

  task automatic check(bit ok, string req_tag, string what, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req_tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(posedge clk) if (!rst) started <= 1;

  always @(negedge clk) begin
    if (started || rst) begin
      for (int g = 0; g < 3; g++) begin
        logic e_ce, e_we, e_oe, e_dq;
        logic [1:0] e_be;
        string tg;
        e_ce = 1; e_we = 1; e_oe = 1; e_dq = 0; e_be = 2'b11; tg = "R1";
        if (act == 1 && t < RDC) begin
          e_ce = 0; e_oe = 0; e_be = ~m_mask; tg = "R3";
        end else if (act == 1) tg = "R5";
        else if (act == 2) begin
          e_dq = 1;
          if (t >= 1 && t <= WRC) begin
            e_ce = 0; e_we = 0; e_be = ~m_mask; tg = "R6";
          end else if (g == 0) begin
            e_ce = 0; e_be = ~m_mask; tg = "R6";
          end else if (g == 1) begin
            e_we = 0; e_be = ~m_mask; tg = "R8";
          end else begin
            e_ce = 0; e_we = 0; tg = "R9";
          end
        end
        if (m_mask == 2'b00 && act != 0) tg = {tg, "/R11"};
        check({ce[g], we[g], oe[g], be[g], dqoe[g]} == {e_ce, e_we, e_oe, e_be, e_dq}, tg,
              $sformatf("u%0d strobes {ce,we,oe,be,dq_oe}", g),
              64'({ce[g], we[g], oe[g], be[g], dqoe[g]}), 64'({e_ce, e_we, e_oe, e_be, e_dq}));
        if (act != 0 && !rst) begin
          check(ad[g] == m_addr, tg, $sformatf("u%0d address", g), 64'(ad[g]), 64'(m_addr));
          if (act == 2)
            check(dqo[g] == m_data, "R6", $sformatf("u%0d write data", g), 64'(dqo[g]), 64'(m_data));
        end
        check({rdy[g], dn[g]} == {(act == 0), exp_done}, (act == 0) ? "R4" : "R10",
              $sformatf("u%0d {ready,done}", g), 64'({rdy[g], dn[g]}), 64'({(act == 0), exp_done}));
        if (exp_done && !rst)
          check(rd[g] == exp_rd, (m_mask == 2'b00) ? "R11" : "R4",
                $sformatf("u%0d rdata", g), 64'(rd[g]), 64'(exp_rd));
      end
    end
  end

  task automatic op(bit w, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    while (!rdy[0]) @(negedge clk);
    req = 1; req_we = w; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle_wait();
    @(negedge clk);
    while (!rdy[0]) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: first cycles after reset are covered by the per-cycle comparison
    @(negedge clk);
    op(1, 18'h00000, 16'h1234, 2'b11);
    op(1, 18'h3FFFF, 16'hABCD, 2'b11);
    op(0, 18'h00000, 16'h0000, 2'b11);
    op(0, 18'h3FFFF, 16'h0000, 2'b01);
    op(0, 18'h3FFFF, 16'h0000, 2'b10);
    op(1, 18'h00005, 16'hFFFF, 2'b10);
    op(0, 18'h00005, 16'h0000, 2'b11);
    // R11: empty mask leaves memory alone and reads zero
    op(1, 18'h00005, 16'h1111, 2'b00);
    op(0, 18'h00005, 16'h0000, 2'b00);
    op(0, 18'h00005, 16'h0000, 2'b11);
    // R10: request while busy is ignored
    op(0, 18'h00000, 16'h0000, 2'b11);
    req = 1; req_we = 1; req_addr = 18'h00000; req_wdata = 16'h9999; req_mask = 2'b11;
    @(negedge clk);
    req = 0;
    idle_wait();
    op(0, 18'h00000, 16'h0000, 2'b11);
    // R5: write issued at the first ready cycle after a read
    op(1, 18'h01234, 16'h5A5A, 2'b11);
    op(0, 18'h01234, 16'h0000, 2'b11);
    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(lf[0], {15'h0, lf[3:1]}, lf ^ 16'h3C3C, lf[5:4]);
    end
    idle_wait();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog expired: actual hung expected ready");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule